// File: doc/BRIEF.md
# Watchdog Timer with Standby Wakeup

This block is an 8-bit up-counter driven through a selectable prescaler. It serves three purposes. In watchdog mode, software must keep rewriting the count. If the count runs past its top value, the block raises an overflow flag and emits a fixed-length external overflow pulse. It can also emit a longer internal reset pulse. In interval mode, each overflow latches an interrupt flag, and the counter wraps and keeps counting.

The third purpose is the standby wake path. While the chip is in standby and the timer is disabled, a rising edge on the wake interrupt input starts the counter from its preloaded value. When that count overflows, the block emits a clock-release pulse so that the oscillator can settle before the clocks return.

Software reaches three registers through a single-cycle write strobe and an address. It reads them back on plain output pins. The external reset pin clears everything asynchronously, including any pulse that is in progress.

Top module: `wdt_standby`

## Requirements
- R1: The control field sel (control bits 2:0) picks the prescaler ratio. Codes 0 to 7 divide the clock by 1, 64, 128, 256, 512, 1024, 4096 and 16384. The counter advances once per prescaler period, counted from the cycle after it starts.
- R2: Control bit 7 (en) starts the counter, and clearing it stops the counter. Control bit 6 selects watchdog mode (1) or interval mode (0). The control register is at address 0.
- R3: A write to address 1 loads the counter and restarts the prescaler. If that write lands in the same cycle as the terminal tick at 0xFF, the write wins and no overflow occurs.
- R4: A watchdog overflow sets the flag in status bit 7 (address 2). It also drives wdt_ovf_o high for exactly 64 cycles, starting one cycle after the overflow.
- R5: When status bit 6 (reset enable) is 1, the same overflow also drives int_rst_o for exactly 128 cycles. When it is 0, int_rst_o stays low.
- R6: Writing 0 to status bit 7 clears the flag, and writing 1 to it has no effect. If an overflow and a clearing write fall in the same cycle, the flag ends up set.
- R7: An interval-mode overflow sets control bit 5, which drives irq_o. It produces no overflow or reset pulse, and the counter wraps to 0 and keeps counting. Writing control bit 5 as 0 clears the flag.
- R8: While stby_i is 1 and en is 0, a rising edge on nmi_i starts counting from the current counter value. With stby_i at 0, an edge on nmi_i does nothing.
- R9: A standby-count overflow drives clk_release_o for one cycle and stops the count. It does not set the overflow flag.
- R10: A low level on rst_n asynchronously clears every register, both pulses and the standby count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 count, 2 status |
| wr_data | input | 8 | Write data |
| stby_i | input | 1 | Chip is in standby |
| nmi_i | input | 1 | Wake interrupt input |
| ctrl_o | output | 8 | Control register {en, mode, itf, 0, 0, sel} |
| cnt_o | output | 8 | Counter value |
| stat_o | output | 8 | Status register {flag, reset enable, 000000} |
| wdt_ovf_o | output | 1 | External overflow pulse |
| int_rst_o | output | 1 | Internal reset pulse |
| irq_o | output | 1 | Interval interrupt |
| clk_release_o | output | 1 | Standby clock release pulse |

## Verification
Two collisions are forced deliberately. The bench waits until cnt_o reads 0xFF at ratio 1 and then issues its write in that exact cycle, so the write is sampled on the terminal tick. A refresh of the count at that moment must suppress the overflow entirely. A flag-clearing write to the status register at that moment must lose to the flag set. The reference model gives precedence in the same way, and its outputs are compared with the design's on every cycle, so any drift in the result or in pulse timing is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DIV_W = 14;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CNT  = 2'd1,
    A_STAT = 2'd2
  } wdt_addr_e;

  typedef struct packed {
    logic       en;
    logic       mode;
    logic       itf;
    logic [2:0] sel;
  } wdt_ctrl_t;

  // log2 of the prescaler ratio for each select code
  function automatic logic [3:0] sel_shift(input logic [2:0] s);
    case (s)
      3'd0:    sel_shift = 4'd0;
      3'd1:    sel_shift = 4'd6;
      3'd2:    sel_shift = 4'd7;
      3'd3:    sel_shift = 4'd8;
      3'd4:    sel_shift = 4'd9;
      3'd5:    sel_shift = 4'd10;
      3'd6:    sel_shift = 4'd12;
      default: sel_shift = 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  import wdt_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = DIV_W'((32'd1 << sel_shift(sel)) - 32'd1);
    tick = run && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (!run || clr) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int W = $clog2(LEN + 1);

  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (fire)         left_q <= W'(LEN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/wdt_standby.sv
module wdt_standby #(
  parameter int CNT_W   = 8,
  parameter int OVF_CYC = 64,
  parameter int RST_CYC = 128,
  parameter int DIV_W   = wdt_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             stby_i,
  input  logic             nmi_i,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       stat_o,
  output logic             wdt_ovf_o,
  output logic             int_rst_o,
  output logic             irq_o,
  output logic             clk_release_o
);
  import wdt_pkg::*;

  wdt_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, rste_q;
  logic             sby_q, nmi_q, rel_q;

  logic wr_ctrl, wr_cnt, wr_stat;
  logic run, tick, term;
  logic wd_evt, iv_evt, sb_evt;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == A_CTRL);
    wr_cnt  = wr_en && (wr_addr == A_CNT);
    wr_stat = wr_en && (wr_addr == A_STAT);
    run     = ctrl_q.en || sby_q;
    term    = tick && (cnt_q == '1) && !wr_cnt;
    wd_evt  = term && ctrl_q.en && ctrl_q.mode;
    iv_evt  = term && ctrl_q.en && !ctrl_q.mode;
    sb_evt  = term && sby_q && !ctrl_q.en;
  end

  wdt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .clr  (wr_cnt),
    .sel  (ctrl_q.sel),
    .tick (tick)
  );

  // counter: a software load beats the prescaler tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  // control register; interval flag set beats software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= wr_data[7];
        ctrl_q.mode <= wr_data[6];
        ctrl_q.sel  <= wr_data[2:0];
      end
      if (iv_evt)                    ctrl_q.itf <= 1'b1;
      else if (wr_ctrl && !wr_data[5]) ctrl_q.itf <= 1'b0;
    end
  end

  // status register; overflow flag set beats software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rste_q <= 1'b0;
    end else begin
      if (wr_stat) rste_q <= wr_data[6];
      if (wd_evt)                      flag_q <= 1'b1;
      else if (wr_stat && !wr_data[7]) flag_q <= 1'b0;
    end
  end

  // standby settling count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      sby_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      rel_q <= sb_evt;
      if (sb_evt || !stby_i || ctrl_q.en) sby_q <= 1'b0;
      else if (nmi_i && !nmi_q)            sby_q <= 1'b1;
    end
  end

  wdt_pulse #(.LEN(OVF_CYC)) u_ovf_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (wd_evt),
    .active(wdt_ovf_o)
  );

  wdt_pulse #(.LEN(RST_CYC)) u_rst_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (wd_evt && rste_q),
    .active(int_rst_o)
  );

  assign ctrl_o        = {ctrl_q.en, ctrl_q.mode, ctrl_q.itf, 2'b00, ctrl_q.sel};
  assign cnt_o         = cnt_q;
  assign stat_o        = {flag_q, rste_q, 6'b000000};
  assign irq_o         = ctrl_q.itf;
  assign clk_release_o = rel_q;
endmodule

// File: rtl/wdt_standby_chk.sv
module wdt_standby_chk #(
  parameter int OVF_CYC = 64,
  parameter int RST_CYC = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] stat_o,
  input logic       wdt_ovf_o,
  input logic       int_rst_o,
  input logic       irq_o,
  input logic       clk_release_o
);
  logic [15:0] ovf_run, rst_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_run <= '0;
      rst_run <= '0;
    end else begin
      ovf_run <= wdt_ovf_o ? ovf_run + 16'd1 : 16'd0;
      rst_run <= int_rst_o ? rst_run + 16'd1 : 16'd0;
    end
  end

  p_flag_on_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_ovf_o) |-> stat_o[7]);

  p_ovf_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_ovf_o) |-> (ovf_run == 16'(OVF_CYC)));

  p_rst_with_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst_o) |-> $rose(wdt_ovf_o));

  p_rst_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst_o) |-> (rst_run == 16'(RST_CYC)));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$rose(wdt_ovf_o));

  p_rel_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_release_o |-> !$rose(stat_o[7]));

  p_rel_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_release_o |=> !clk_release_o);
endmodule

bind wdt_standby wdt_standby_chk #(.OVF_CYC(OVF_CYC), .RST_CYC(RST_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stat_o       (stat_o),
  .wdt_ovf_o    (wdt_ovf_o),
  .int_rst_o    (int_rst_o),
  .irq_o        (irq_o),
  .clk_release_o(clk_release_o)
);

// File: tb/wdt_standby_test.sv
module wdt_standby_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       stby_i = 1'b0;
  logic       nmi_i = 1'b0;
  logic [7:0] ctrl_o, cnt_o, stat_o;
  logic       wdt_ovf_o, int_rst_o, irq_o, clk_release_o;

  int checks = 0, fails = 0, cycles = 0;
  bit started = 1'b0;

  wdt_standby uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stby_i(stby_i), .nmi_i(nmi_i), .ctrl_o(ctrl_o), .cnt_o(cnt_o), .stat_o(stat_o),
    .wdt_ovf_o(wdt_ovf_o), .int_rst_o(int_rst_o), .irq_o(irq_o),
    .clk_release_o(clk_release_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit m_en, m_mode, m_itf, m_flag, m_rste, m_sby, m_nmi_q, m_rel;
  int m_sel, m_cnt, m_div, m_ovfc, m_rstc;

  function automatic int ratio_of(input int s);
    int tbl[8] = '{1, 64, 128, 256, 512, 1024, 4096, 16384};
    return tbl[s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_itf = 0; m_flag = 0; m_rste = 0; m_sby = 0;
      m_nmi_q = 0; m_rel = 0; m_sel = 0; m_cnt = 0; m_div = 0; m_ovfc = 0; m_rstc = 0;
    end else begin
      bit wc, wctl, wst, run, tick, term, wd, iv, sb;
      int r;
      wctl = wr_en && wr_addr == 2'd0;
      wc   = wr_en && wr_addr == 2'd1;
      wst  = wr_en && wr_addr == 2'd2;
      run  = m_en || m_sby;
      r    = ratio_of(m_sel);
      tick = run && ((m_div % r) == r - 1);
      term = tick && m_cnt == 255 && !wc;
      wd   = term && m_en && m_mode;
      iv   = term && m_en && !m_mode;
      sb   = term && m_sby && !m_en;
      m_div = (!run || wc) ? 0 : (m_div + 1) % 16384;
      if (wc) m_cnt = wr_data; else if (tick) m_cnt = (m_cnt + 1) % 256;
      m_ovfc = wd ? 64 : (m_ovfc > 0 ? m_ovfc - 1 : 0);
      m_rstc = (wd && m_rste) ? 128 : (m_rstc > 0 ? m_rstc - 1 : 0);
      if (wd) m_flag = 1; else if (wst && !wr_data[7]) m_flag = 0;
      if (iv) m_itf = 1; else if (wctl && !wr_data[5]) m_itf = 0;
      if (sb || !stby_i || m_en) m_sby = 0;
      else if (nmi_i && !m_nmi_q) m_sby = 1;
      m_nmi_q = nmi_i;
      m_rel = sb;
      if (wst) m_rste = wr_data[6];
      if (wctl) begin m_en = wr_data[7]; m_mode = wr_data[6]; m_sel = wr_data[2:0]; end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", what, cycles, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (started) begin
      chk("R2 R7 control", ctrl_o, {m_en, m_mode, m_itf, 2'b00, 3'(m_sel)});
      chk("R1 R3 count", cnt_o, m_cnt);
      chk("R4 R6 status", stat_o, {m_flag, m_rste, 6'b0});
      chk("R4 overflow pulse", wdt_ovf_o, m_ovfc > 0);
      chk("R5 internal reset", int_rst_o, m_rstc > 0);
      chk("R7 irq", irq_o, m_itf);
      chk("R9 clock release", clk_release_o, m_rel);
      if (!rst_n) chk("R10 cleared", {ctrl_o, cnt_o, stat_o}, 0);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr_here(input int a, input int d);
    #1; wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_here(a, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(posedge clk); started = 1'b1;
    idle(2); #1 rst_n = 1'b1;
    idle(3);                                 // R10 reset state

    // R2 R4: watchdog overflow, no internal reset
    wr(2, 8'h00); wr(1, 8'hF0); wr(0, 8'hC0);
    idle(100);
    wr(0, 8'h00); idle(5);                   // R2 stop
    // R6: writing 1 keeps the flag, writing 0 clears it
    wr(2, 8'h80); idle(2); wr(2, 8'h00); idle(2);

    // R5: internal reset enabled
    wr(2, 8'h40); wr(1, 8'hF0); wr(0, 8'hC0);
    idle(160); wr(0, 8'h00); wr(2, 8'h00);

    // R3: periodic refresh at ratio 64 keeps overflow away
    wr(1, 8'h00); wr(0, 8'hC1);
    for (int i = 0; i < 5; i++) begin idle(200); wr(1, 8'h00); end
    wr(0, 8'h00);

    // R3 collision: refresh on the terminal tick suppresses overflow
    wr(1, 8'hF0); wr(0, 8'hC0);
    @(negedge clk);
    while (cnt_o != 8'hFF) @(negedge clk);
    wr_here(1, 8'h00);
    idle(20); wr(0, 8'h00);

    // R6 collision: clear on the terminal tick loses to the set
    wr(1, 8'hF0); wr(0, 8'hC0);
    @(negedge clk);
    while (cnt_o != 8'hFF) @(negedge clk);
    wr_here(2, 8'h00);
    idle(70); wr(0, 8'h00); wr(2, 8'h00);

    // R7: interval mode wraps and raises irq
    wr(1, 8'hF0); wr(0, 8'h80);
    idle(40);
    wr(0, 8'h80); idle(10);                  // R7 clear flag, keep running
    wr(0, 8'h00);

    // R8: nmi edge without standby does nothing
    wr(1, 8'hF8);
    @(negedge clk); #1 nmi_i = 1'b1; idle(3); #1 nmi_i = 1'b0; idle(5);
    // R8 R9: standby wake count
    #1 stby_i = 1'b1; idle(5);
    #1 nmi_i = 1'b1; idle(20);
    #1 nmi_i = 1'b0; stby_i = 1'b0; idle(3);

    // R1: every prescaler ratio
    for (int s = 0; s < 8; s++) begin
      wr(1, 8'hFE); wr(0, 8'h80 | s);
      idle(2 * ratio_of(s) + 4);
      wr(0, 8'h00); wr(0, 8'h00);
    end

    // R10: external reset in the middle of both pulses
    wr(2, 8'h40); wr(1, 8'hFC); wr(0, 8'hC0);
    idle(20);
    @(negedge clk); #1 rst_n = 1'b0;
    idle(2); #1 rst_n = 1'b1;
    idle(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule